// File: doc/BRIEF.md
# End-Around Carry Counter

This block takes a stream of signed b-bit words and treats each word as an unsigned number by reading its two's-complement bit pattern. It adds the words into a wide total. Then it folds the total back into a b-bit register in an end-around way. On each fold, the part above bit b-1 is the carry. That carry is added onto the low part, and its value is added to a running carry count. Folding repeats until a fold produces no carry.

The results are the total number of carries the folding produced and the final b-bit residue. This shows how much carry traffic a packed low-precision accumulation generates. Every carry is counted, including the top carry that a real b-bit register would lose.

A job begins with a one-cycle `start` in idle. Words then arrive with `in_valid`, and the word marked `in_last` closes the stream. A one-cycle `done` reports that the results are ready. The results stay unchanged until the next job begins.

Top module: `eac_carry_counter`

## Requirements
- R1: While reset is high and after it is released, `busy`, `done`, `carry_count` and `residue` are all zero.
- R2: A `start` pulse while idle clears the running total, `carry_count` and `residue` to zero, and `busy` is high from the next cycle on. A `start` while `busy` is high has no effect on the job in flight.
- R3: Each word accepted during accumulation adds its value as an unsigned number. A negative word x adds x + 2^W and a non-negative word adds x, so the word -1 adds 2^W - 1.
- R4: Accumulation ends with the accepted word that has `in_last` high. Folding then starts with the carry equal to the full total and the residue equal to zero.
- R5: Each fold takes one clock cycle and computes s = carry + residue. The new carry is floor(s / 2^W), the new residue is s mod 2^W, and the new carry is added to `carry_count`. Folding stops after the first fold whose new carry is zero. Every carry is counted, including the most significant one.
- R6: Let the last word be accepted at clock edge 0 and let the job need k folds, counting the final fold with zero carry. Then `done` is high for exactly the one cycle that follows edge k.
- R7: After `done`, `carry_count` and `residue` hold their values until the next accepted `start`, whatever `in_valid`, `in_last` and `in_data` do in between.
- R8: Cycles with `in_valid` low during accumulation add nothing to the total, and words offered while the block is folding are ignored.
- R9: A stream whose total is zero finishes after a single fold, with `carry_count` zero and `residue` zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a job when the block is idle |
| in_valid | input | 1 | `in_data` holds a word to accumulate |
| in_last | input | 1 | The word offered is the final word of the stream |
| in_data | input | W | Signed word, two's complement |
| busy | output | 1 | A job is accumulating or folding |
| done | output | 1 | One-cycle pulse when the results are ready |
| carry_count | output | W+clog2(MAX_N) | Total number of carries produced by folding |
| residue | output | W | Final b-bit residue |

## Verification
The fold count k of every job is computed in the bench from R5 alone. The cycle of each word is recorded, and `done` is expected exactly k edges after the edge that takes the last word. A scoreboard entry carries the due cycle together with the expected count and residue. The monitor samples at the falling edge, so a `done` that arrives early, arrives late, or repeats is reported. Results are also compared at the falling edge several cycles after `done`, while the inputs are being toggled. A `start` is sampled one edge after it is applied, to see the cleared outputs.

// File: rtl/eac_pkg.sv
package eac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_FOLD  = 2'd2
    } eac_state_e;

    // Width of a register able to hold n_max words of w bits each at full scale.
    function automatic int total_width(input int w, input int n_max);
        return w + $clog2(n_max);
    endfunction

endpackage

// File: rtl/eac_ctrl.sv
module eac_ctrl
    import eac_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       in_valid,
    input  logic       in_last,
    input  logic       fold_zero,
    output eac_state_e state,
    output logic       clear,
    output logic       accept,
    output logic       load,
    output logic       fold_en,
    output logic       done
);

    eac_state_e state_q, state_d;
    logic       done_q;

    always_comb begin
        state_d = state_q;
        clear   = 1'b0;
        accept  = 1'b0;
        load    = 1'b0;
        fold_en = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    clear   = 1'b1;
                    state_d = ST_ACCUM;
                end
            end
            ST_ACCUM: begin
                accept = in_valid;
                if (in_valid && in_last) begin
                    load    = 1'b1;
                    state_d = ST_FOLD;
                end
            end
            ST_FOLD: begin
                fold_en = 1'b1;
                if (fold_zero) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_FOLD) && fold_zero;
        end
    end

    assign state = state_q;
    assign done  = done_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> (state_q == ST_IDLE)); // R6

endmodule

// File: rtl/eac_accum.sv
module eac_accum #(
    parameter int W  = 8,
    parameter int SW = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          accept,
    input  logic [W-1:0]  in_data,
    output logic [SW-1:0] total,
    output logic [SW-1:0] total_next
);

    logic [SW-1:0] total_q;

    // The two's-complement pattern read as unsigned equals x + 2^W for x < 0.
    assign total_next = total_q + SW'(in_data);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            total_q <= '0;
        end else if (accept) begin
            total_q <= total_next;
        end
    end

    assign total = total_q;

    AST_TOTAL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!accept && !clear) |=> $stable(total_q)); // R8

endmodule

// File: rtl/eac_fold.sv
module eac_fold #(
    parameter int W  = 8,
    parameter int SW = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          load,
    input  logic          fold_en,
    input  logic [SW-1:0] load_value,
    output logic [SW-1:0] carry,
    output logic [W-1:0]  residue,
    output logic [SW-1:0] count,
    output logic          fold_zero
);

    localparam int TW = SW + 1;
    localparam int CW = TW - W;

    logic [SW-1:0] carry_q;
    logic [W-1:0]  res_q;
    logic [SW-1:0] count_q;
    logic [TW-1:0] step_sum;
    logic [CW-1:0] step_carry;
    logic [W-1:0]  step_res;

    assign step_sum   = TW'(carry_q) + TW'(res_q);
    assign step_carry = step_sum[TW-1:W];
    assign step_res   = step_sum[W-1:0];
    assign fold_zero  = (step_carry == '0);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            carry_q <= '0;
            res_q   <= '0;
            count_q <= '0;
        end else if (load) begin
            carry_q <= load_value;
            res_q   <= '0;
            count_q <= '0;
        end else if (fold_en) begin
            carry_q <= SW'(step_carry);
            res_q   <= step_res;
            count_q <= count_q + SW'(step_carry);
        end
    end

    assign carry   = carry_q;
    assign residue = res_q;
    assign count   = count_q;

    AST_CARRY_NONINC: assert property (@(posedge clk) disable iff (rst)
        (fold_en && !clear && !load) |=> (carry_q <= $past(carry_q))); // R5

    AST_COUNT_NONDEC: assert property (@(posedge clk) disable iff (rst)
        (fold_en && !clear && !load) |=> (count_q >= $past(count_q))); // R5

    AST_LOAD_INIT: assert property (@(posedge clk) disable iff (rst)
        (load && !clear) |=> (res_q == '0 && count_q == '0)); // R4

endmodule

// File: rtl/eac_carry_counter.sv
module eac_carry_counter
    import eac_pkg::*;
#(
    parameter int W     = 8,
    parameter int MAX_N = 64,
    localparam int SW   = total_width(W, MAX_N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          in_valid,
    input  logic          in_last,
    input  logic [W-1:0]  in_data,
    output logic          busy,
    output logic          done,
    output logic [SW-1:0] carry_count,
    output logic [W-1:0]  residue
);

    localparam int XW = SW + W + 1;

    eac_state_e    state;
    logic          clear, accept, load, fold_en, fold_zero;
    logic [SW-1:0] total, total_next, carry;

    eac_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .fold_zero (fold_zero),
        .state     (state),
        .clear     (clear),
        .accept    (accept),
        .load      (load),
        .fold_en   (fold_en),
        .done      (done)
    );

    eac_accum #(.W(W), .SW(SW)) u_accum (
        .clk        (clk),
        .rst        (rst),
        .clear      (clear),
        .accept     (accept),
        .in_data    (in_data),
        .total      (total),
        .total_next (total_next)
    );

    eac_fold #(.W(W), .SW(SW)) u_fold (
        .clk        (clk),
        .rst        (rst),
        .clear      (clear),
        .load       (load),
        .fold_en    (fold_en),
        .load_value (total_next),
        .carry      (carry),
        .residue    (residue),
        .count      (carry_count),
        .fold_zero  (fold_zero)
    );

    assign busy = (state != ST_IDLE);

    // Each fold trades one unit of carry for 2^W - 1 taken out of the low part,
    // so carry + residue + count * (2^W - 1) stays equal to the total.
    logic [XW-1:0] conserved;
    assign conserved = XW'(carry) + XW'(residue)
                     + XW'(carry_count) * ((XW'(1) << W) - XW'(1));

    AST_SUM_CONSERVED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FOLD) |-> (conserved == XW'(total))); // R5

    AST_DONE_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
        done |-> (carry == '0)); // R5

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(carry_count) && $stable(residue))); // R7

endmodule

// File: tb/eac_carry_counter_bench.sv
module eac_carry_counter_bench;

    localparam int W      = 8;
    localparam int MAX_N  = 64;
    localparam int SW     = W + $clog2(MAX_N);
    localparam int CLK_NS = 10;

    typedef struct {
        longint cnt;
        longint res;
        int     due;
        string  tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_last = 1'b0;
    logic [W-1:0]  in_data = '0;
    logic          busy, done;
    logic [SW-1:0] carry_count;
    logic [W-1:0]  residue;

    int   n_checks = 0;
    int   n_fail = 0;
    int   cyc = 0;
    int   items[$];
    exp_t exp_q[$];
    logic done_prev = 1'b0;

    eac_carry_counter #(.W(W), .MAX_N(MAX_N)) u_eac_carry_counter (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .in_valid    (in_valid),
        .in_last     (in_last),
        .in_data     (in_data),
        .busy        (busy),
        .done        (done),
        .carry_count (carry_count),
        .residue     (residue)
    );

    always #(CLK_NS/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input logic ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: compares every done pulse against the scoreboard.
    always @(negedge clk) begin
        if (!rst) begin
            if (done && done_prev) check(1'b0, "R6 done longer than one cycle", 1, 0);
            if (done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(cyc == e.due, {e.tag, " R6 done cycle"}, cyc, e.due);
                    check(longint'(carry_count) == e.cnt, {e.tag, " R5 carry count"}, carry_count, e.cnt);
                    check(longint'(residue) == e.res, {e.tag, " R5 residue"}, residue, e.res);
                end
            end
            done_prev <= done;
        end
    end

    // Driver: runs one job from items, pushing the expected result when the last word goes out.
    task automatic run_job(input string tag, input int gap, input bit poke);
        longint total = 0;
        longint c, r, cnt, s;
        int     k = 0;
        exp_t   e;
        foreach (items[i]) total += (items[i] < 0) ? items[i] + (1 << W) : items[i];
        c = total; r = 0; cnt = 0;
        do begin
            s = c + r;
            c = s >> W;
            r = s % (1 << W);
            cnt += c;
            k++;
        end while (c != 0);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        foreach (items[i]) begin
            for (int g = 0; g < gap; g++) begin
                in_valid = 1'b0; in_data = 8'hAA; in_last = 1'b1;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_data  = W'(items[i]);
            in_last  = (i == items.size() - 1);
            if (in_last) begin
                e.cnt = cnt; e.res = r; e.due = cyc + 1 + k; e.tag = tag;
                exp_q.push_back(e);
            end
            @(negedge clk);
        end
        if (poke) begin
            // R2 start and R8 words while folding must not disturb the job.
            start = 1'b1; in_valid = 1'b1; in_data = 8'h7F; in_last = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        in_valid = 1'b0; in_last = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [SW-1:0] hold_cnt;
        logic [W-1:0]  hold_res;
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1 busy in reset", busy, 0);
        check(done == 1'b0, "R1 done in reset", done, 0);
        rst = 1'b0;
        @(negedge clk);
        check(carry_count == '0, "R1 count after reset", carry_count, 0);
        check(residue == '0, "R1 residue after reset", residue, 0);

        items = '{5};                   run_job("R3 single", 0, 0);
        items = '{0};                   run_job("R9 zero", 0, 0);
        items = '{1, -1};               run_job("R3 minus one", 0, 0);
        items = '{-1, -1, 1};           run_job("R5 double carry", 1, 0);
        items = '{-128};                run_job("R3 most negative", 0, 0);
        items = '{3, -7, 100, -2, 64};  run_job("R8 gaps", 2, 0);
        items = {};
        for (int i = 0; i < MAX_N; i++) items.push_back(-1);
        run_job("R4 full scale", 0, 1);

        // R7: results hold while inputs move in idle.
        hold_cnt = carry_count; hold_res = residue;
        in_valid = 1'b1; in_last = 1'b1; in_data = 8'h33;
        repeat (4) @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        check(carry_count == hold_cnt, "R7 count held", carry_count, hold_cnt);
        check(residue == hold_res, "R7 residue held", residue, hold_res);
        check(busy == 1'b0, "R7 stays idle", busy, 0);

        // R2: start clears outputs and raises busy.
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(carry_count == '0, "R2 count cleared", carry_count, 0);
        check(residue == '0, "R2 residue cleared", residue, 0);
        check(busy == 1'b1, "R2 busy after start", busy, 1);
        in_valid = 1'b1; in_data = 8'd9; in_last = 1'b1;
        begin
            exp_t e;
            e.cnt = 0; e.res = 9; e.due = cyc + 2; e.tag = "R4 after clear";
            exp_q.push_back(e);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);

        items = {};
        for (int i = 0; i < 40; i++) items.push_back(((i * 37 + 11) % 256) - 128);
        run_job("R5 mixed", 0, 0);

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule